// File: doc/BRIEF.md
# Clearable Capture Flop

This block is a storage element, one bit wide by default, that takes a new value on its active clock edge only when its enable is high. The value it takes comes from a fixed order of choice: a synchronous clear wins, then a synchronous load of an alternate data input, and only then the ordinary data input. An active-low asynchronous clear overrides everything at once. The element always powers up holding zero. Its initial state cannot be changed.

Two build-time variants wrap the same core. The first is set emulation. It inverts the data and alternate-data paths on the way in and the output on the way out, so the asynchronous clear (and the synchronous clear) show a one at `q`, while loaded data passes through unchanged. The second variant moves capture to the falling clock edge by clocking the core from the inverted clock. Because the core always starts at zero, a part that needs async clear with an initial one, or async set with an initial zero, cannot be built from it.

Top module: `sync_ctl_flop`

## Requirements
- R1: After power-up, and after `aclr_n` is released, `q` shows the clear value (all zeros by default) until the next capture.
- R2: While `aclr_n` is low, `q` shows the clear value at once, also in the middle of a clock cycle, and holds it across clock edges whatever `ena`, `sclr`, `sload`, `datain` and `sdata` do.
- R3: With `aclr_n` high and `ena` high, `q` takes its next value on the active clock edge (rising by default) and keeps it until the next capture.
- R4: With `ena` low, `q` keeps its value across the active edge, and `sclr`, `sload`, `datain` and `sdata` have no effect.
- R5: With `ena` high and `sclr` high, the captured value is the clear value, regardless of `sload`, `datain` and `sdata`.
- R6: With `ena` high, `sclr` low and `sload` high, `q` takes `sdata`, and `datain` is ignored.
- R7: With `ena` high, `sclr` low and `sload` low, `q` takes `datain`.
- R8: With `SET_EMULATION` = 1, the clear value is all ones. Both the asynchronous clear and `sclr` make `q` read one, while `datain` and `sdata` appear at `q` without inversion.
- R9: With `FALL_EDGE` = 1, capture happens on the falling edge of `clk` only, and `q` does not change on the rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the active edge is chosen by `FALL_EDGE` |
| aclr_n | input | 1 | Asynchronous clear, active low |
| ena | input | 1 | Clock enable; gates every synchronous change |
| sclr | input | 1 | Synchronous clear, highest synchronous priority |
| sload | input | 1 | Selects `sdata` instead of `datain` |
| datain | input | WIDTH | Ordinary data input |
| sdata | input | WIDTH | Alternate data input for synchronous load |
| q | output | WIDTH | Stored value as seen outside the block |

## Verification
Two actions can land in the same cycle. One is an asynchronous clear arriving between edges while the enable still requests a capture. The other is a synchronous clear, a load and ordinary data all requested together. A stimulus table covers all eight combinations of enable, clear and load against a running model of the stored bit. The asynchronous clear is then dropped two nanoseconds after an edge that captured a one. The output is judged before the next edge, again after that edge while data is still offered, and once more after release. A second instance, built with set emulation and falling-edge capture, repeats these collisions with the phases shifted by half a period.

// File: rtl/sync_ctl_flop_pkg.sv
package sync_ctl_flop_pkg;

  // Strobes sent from the control decode to the storage datapath.
  typedef struct packed {
    logic capture;    // take a new value on the active edge
    logic forceZero;  // core next value is zero
    logic pickAlt;    // core next value comes from the alternate input
  } ffStrobes_t;

endpackage

// File: rtl/sync_ctl_flop_ctrl.sv
module sync_ctl_flop_ctrl
  import sync_ctl_flop_pkg::*;
(
  input  logic       ena,
  input  logic       sclr,
  input  logic       sload,
  output ffStrobes_t strobes
);

  // Fixed order of choice: enable gates everything, then clear, then load.
  always_comb begin
    strobes           = '0;
    strobes.capture   = ena;
    strobes.forceZero = sclr;
    strobes.pickAlt   = sload & ~sclr;
  end

endmodule

// File: rtl/sync_ctl_flop_dp.sv
module sync_ctl_flop_dp
  import sync_ctl_flop_pkg::*;
#(
  parameter int WIDTH         = 1,
  parameter int SET_EMULATION = 0,
  parameter int FALL_EDGE     = 0
) (
  input  logic             clk,
  input  logic             aclr_n,
  input  ffStrobes_t       strobes,
  input  logic [WIDTH-1:0] datain,
  input  logic [WIDTH-1:0] sdata,
  output logic [WIDTH-1:0] q
);

  localparam bit INVERT_LEVEL = (SET_EMULATION != 0);
  localparam bit NEG_CLOCK    = (FALL_EDGE != 0);

  logic [WIDTH-1:0] coreData;
  logic [WIDTH-1:0] coreAlt;
  logic [WIDTH-1:0] coreNext;
  logic [WIDTH-1:0] coreState = '0;  // the core always starts at zero

  // Input side of the level-inversion wrapper.
  generate
    if (INVERT_LEVEL) begin : g_invIn
      assign coreData = ~datain;
      assign coreAlt  = ~sdata;
    end else begin : g_passIn
      assign coreData = datain;
      assign coreAlt  = sdata;
    end
  endgenerate

  always_comb begin
    if (strobes.forceZero)    coreNext = '0;
    else if (strobes.pickAlt) coreNext = coreAlt;
    else                      coreNext = coreData;
  end

  // Storage: the active edge is chosen by the clock-inversion variant.
  generate
    if (NEG_CLOCK) begin : g_fallCore
      always_ff @(negedge clk or negedge aclr_n) begin
        if (!aclr_n)              coreState <= '0;
        else if (strobes.capture) coreState <= coreNext;
      end
    end else begin : g_riseCore
      always_ff @(posedge clk or negedge aclr_n) begin
        if (!aclr_n)              coreState <= '0;
        else if (strobes.capture) coreState <= coreNext;
      end
    end
  endgenerate

  // Output side of the level-inversion wrapper.
  generate
    if (INVERT_LEVEL) begin : g_invOut
      assign q = ~coreState;
    end else begin : g_passOut
      assign q = coreState;
    end
  endgenerate

endmodule

// File: rtl/sync_ctl_flop.sv
module sync_ctl_flop
  import sync_ctl_flop_pkg::*;
#(
  parameter int WIDTH         = 1,
  parameter int SET_EMULATION = 0,
  parameter int FALL_EDGE     = 0
) (
  input  logic             clk,
  input  logic             aclr_n,
  input  logic             ena,
  input  logic             sclr,
  input  logic             sload,
  input  logic [WIDTH-1:0] datain,
  input  logic [WIDTH-1:0] sdata,
  output logic [WIDTH-1:0] q
);

  ffStrobes_t strobes;

  sync_ctl_flop_ctrl uCtrl (
    .ena     (ena),
    .sclr    (sclr),
    .sload   (sload),
    .strobes (strobes)
  );

  sync_ctl_flop_dp #(
    .WIDTH         (WIDTH),
    .SET_EMULATION (SET_EMULATION),
    .FALL_EDGE     (FALL_EDGE)
  ) uDp (
    .clk     (clk),
    .aclr_n  (aclr_n),
    .strobes (strobes),
    .datain  (datain),
    .sdata   (sdata),
    .q       (q)
  );

endmodule

// File: rtl/sync_ctl_flop_chk.sv
module sync_ctl_flop_chk #(
  parameter int WIDTH         = 1,
  parameter int SET_EMULATION = 0,
  parameter int FALL_EDGE     = 0
) (
  input logic             clk,
  input logic             aclr_n,
  input logic             ena,
  input logic             sclr,
  input logic             sload,
  input logic [WIDTH-1:0] datain,
  input logic [WIDTH-1:0] sdata,
  input logic [WIDTH-1:0] q
);

  localparam logic [WIDTH-1:0] VIS_CLEAR = {WIDTH{SET_EMULATION != 0}};

  logic actClk;
  assign actClk = (FALL_EDGE != 0) ? ~clk : clk;

  // R2 (and R1, R8): the clear value is visible at every edge while clear is held.
  always @(posedge actClk) begin
    a_r2_clear_holds: assert (aclr_n || q == VIS_CLEAR)
      else $error("a_r2_clear_holds: q=%0h", q);
  end

  // R4: enable low keeps the value.
  a_r4_hold: assert property (@(posedge actClk) disable iff (!aclr_n)
    !ena |=> q == $past(q));

  // R5 / R8: synchronous clear shows the clear value.
  a_r5_sclr: assert property (@(posedge actClk) disable iff (!aclr_n)
    (ena && sclr) |=> q == VIS_CLEAR);

  // R6: load takes the alternate input.
  a_r6_load: assert property (@(posedge actClk) disable iff (!aclr_n)
    (ena && !sclr && sload) |=> q == $past(sdata));

  // R7: ordinary data path.
  a_r7_data: assert property (@(posedge actClk) disable iff (!aclr_n)
    (ena && !sclr && !sload) |=> q == $past(datain));

endmodule

bind sync_ctl_flop sync_ctl_flop_chk #(
  .WIDTH         (WIDTH),
  .SET_EMULATION (SET_EMULATION),
  .FALL_EDGE     (FALL_EDGE)
) uChk (
  .clk    (clk),
  .aclr_n (aclr_n),
  .ena    (ena),
  .sclr   (sclr),
  .sload  (sload),
  .datain (datain),
  .sdata  (sdata),
  .q      (q)
);

// File: tb/sim_sync_ctl_flop.sv
`timescale 1ns/1ps
module sim_sync_ctl_flop;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // Default instance: rising edge, clear value zero.
  logic aclrA = 1'b0, enaA = 1'b0, sclrA = 1'b0, sloadA = 1'b0;
  logic [0:0] dA = '0, sA = '0, qA;
  // Variant instance: falling edge, set emulation.
  logic aclrB = 1'b0, enaB = 1'b0, sclrB = 1'b0, sloadB = 1'b0;
  logic [0:0] dB = '0, sB = '0, qB;

  sync_ctl_flop u0 (
    .clk(clk), .aclr_n(aclrA), .ena(enaA), .sclr(sclrA), .sload(sloadA),
    .datain(dA), .sdata(sA), .q(qA)
  );

  sync_ctl_flop #(.WIDTH(1), .SET_EMULATION(1), .FALL_EDGE(1)) u1 (
    .clk(clk), .aclr_n(aclrB), .ena(enaB), .sclr(sclrB), .sload(sloadB),
    .datain(dB), .sdata(sB), .q(qB)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Columns: ena, sclr, sload, datain, sdata, expected q (running from q=0).
  localparam int N_VEC = 16;
  localparam logic [5:0] VEC [N_VEC] = '{
    6'b100_10_1, // R7 data 1
    6'b010_00_1, // R4 hold, clear ignored
    6'b001_00_1, // R4 hold, load ignored
    6'b111_11_0, // R5 clear beats load
    6'b101_01_1, // R6 load sdata
    6'b100_01_0, // R7 data 0
    6'b101_10_0, // R6 load ignores datain
    6'b100_10_1, // R7
    6'b110_11_0, // R5 clear beats data
    6'b000_11_0, // R4 hold at zero
    6'b101_01_1, // R6
    6'b000_00_1, // R4
    6'b011_00_1, // R4 clear+load ignored
    6'b110_00_0, // R5
    6'b100_11_1, // R7
    6'b111_00_0  // R5
  };

  initial begin : watchdog
    #(8 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    #1;
    check("R1 power-up zero", qA[0], 1'b0);
    check("R8 power-up set value", qB[0], 1'b1);
    repeat (2) @(negedge clk);
    aclrA = 1'b1;
    aclrB = 1'b1;
    @(posedge clk); #1;
    check("R1 zero after release", qA[0], 1'b0);

    // Table walk on the rising-edge instance (R3..R7).
    for (int i = 0; i < N_VEC; i++) begin
      @(negedge clk);
      {enaA, sclrA, sloadA, dA[0], sA[0]} = VEC[i][5:1];
      @(posedge clk); #1;
      check($sformatf("R3 table row %0d", i), qA[0], VEC[i][0]);
    end

    // R2: clear dropped mid-cycle while capture of a one is requested.
    @(negedge clk);
    {enaA, sclrA, sloadA, dA[0], sA[0]} = 5'b100_10;
    @(posedge clk); #1;
    check("R3 captured one", qA[0], 1'b1);
    #1 aclrA = 1'b0;
    #1 check("R2 immediate clear", qA[0], 1'b0);
    @(posedge clk); #1;
    check("R2 clear held over edge", qA[0], 1'b0);
    @(negedge clk);
    aclrA = 1'b1;
    #1 check("R1 zero right after release", qA[0], 1'b0);
    @(posedge clk); #1;
    check("R3 capture after release", qA[0], 1'b1);
    enaA = 1'b0;

    // Falling-edge, set-emulation instance (R8, R9).
    @(negedge clk); #1;
    {enaB, sclrB, sloadB, dB[0], sB[0]} = 5'b100_01;
    @(posedge clk); #1;
    check("R9 no capture on rising edge", qB[0], 1'b1);
    @(negedge clk); #1;
    check("R9 capture on falling edge", qB[0], 1'b0);
    dB[0] = 1'b1;
    @(posedge clk); #1;
    check("R9 rising edge ignored", qB[0], 1'b0);
    @(negedge clk); #1;
    check("R8 data not inverted", qB[0], 1'b1);
    dB[0] = 1'b0;
    @(negedge clk); #1;
    check("R7 variant data", qB[0], 1'b0);
    {sclrB, sloadB} = 2'b11;
    @(negedge clk); #1;
    check("R8 sync clear reads one", qB[0], 1'b1);
    {sclrB, sloadB, dB[0], sB[0]} = 4'b0110;
    @(negedge clk); #1;
    check("R6 variant load", qB[0], 1'b0);
    {enaB, sclrB, dB[0], sB[0]} = 4'b0111;
    @(negedge clk); #1;
    check("R4 variant hold", qB[0], 1'b0);
    #1 aclrB = 1'b0;
    #1 check("R8 async clear reads one", qB[0], 1'b1);
    {enaB, sclrB, sloadB, dB[0]} = 4'b1000;
    @(negedge clk); #1;
    check("R2 variant clear held", qB[0], 1'b1);
    aclrB = 1'b1;
    @(negedge clk); #1;
    check("R9 capture after release", qB[0], 1'b0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule